// File: doc/BRIEF.md
# Rotating DRAM Address Traffic Generator

This block drives a continuous stream of memory requests into a single-channel DRAM controller, so that the controller can be loaded and measured under a known access pattern. Traffic is grouped into series. Each series is a fixed number of block-sized accesses at consecutive column positions inside one open page. From one series to the next, the block first moves across the banks in use, then changes the command type, then moves to another rank.

Every request has an address and a read/write flag, and is offered on a valid/ready interface. The address is built by packing row, rank, bank and column fields in one of two field orders. The row comes from a base value held on an input. The channel and block-offset fields are always zero. All configuration inputs are sampled live and are meant to stay fixed while the block runs. The block is reset between configurations.

Top module: `dram_rot_tgen`

## Requirements
- R1: With `map_sel_i` = 0, bits of `req_addr_o` are laid out, from LSB to MSB, as follows:
  - block offset: log2(BLOCK_BYTES) bits
  - channel: CH_W bits
  - bank: log2(NUM_BANKS) bits
  - rank: log2(NUM_RANKS) bits
  - column: log2(PAGE_BYTES/BLOCK_BYTES) bits
  - row: all remaining bits

  The offset and channel fields are always zero.
- R2: With `map_sel_i` = 1, bits from LSB to MSB are laid out as follows:
  - block offset
  - channel
  - column
  - bank
  - rank
  - row

  The field widths are the same as in R1. A `map_sel_i` value of 2 or 3 behaves exactly as 1.
- R3: The bank field equals S mod N. Here S is the series count and N is `banks_util_i` (1..NUM_BANKS), so only banks 0..N-1 appear.
- R4: Each series has K = `seq_pkts_i` requests. The column field starts at 0 and rises by one per request, modulo the number of blocks per page. The row field always equals `row_base_i`.
- R5: The read flag depends on `read_pct_i`:
  - 100: every request is a read.
  - 0: every request is a write.
  - 50: the flag is read when floor(S/N) is even and write when it is odd.
- R6: The rank field equals floor(S/M) mod NUM_RANKS, where M is `max_seq_i`. S returns to 0 after series M*NUM_RANKS-1.
- R7: If `read_pct_i` is any value other than 0, 50 or 100, then `cfg_err_o` is 1 and `req_valid_o` is 0. Otherwise `cfg_err_o` is 0 and `req_valid_o` is 1.
- R8: While `req_valid_o` is high and `req_ready_i` is low, the address and the read flag hold their values. State advances by exactly one request per accepted handshake.
- R9: After reset, the first request has S = 0 and column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| map_sel_i | input | 2 | Address field order select |
| read_pct_i | input | 7 | Read percentage (0, 50 or 100) |
| banks_util_i | input | BANK_W+1 | Number of banks used, N |
| seq_pkts_i | input | PKT_W | Requests per series, K |
| max_seq_i | input | SEQ_W | Series per rank, M |
| row_base_i | input | ROW_W | Row field value |
| req_ready_i | input | 1 | Downstream accepts request |
| req_valid_o | output | 1 | Request offered |
| req_addr_o | output | ADDR_W | Request byte address |
| req_rd_o | output | 1 | 1 = read, 0 = write |
| cfg_err_o | output | 1 | Unsupported read percentage |

## Verification
The embedded properties assume three things about the inputs:
- N, K and M are all at least 1.
- N does not exceed the physical bank count.
- The configuration is stable outside reset.

The stimulus respects these assumptions by changing the configuration only while reset is asserted, and by choosing every count inside its legal range. The read percentage is the one input deliberately pushed outside its legal set, to exercise the error path. `req_ready_i` is toggled pseudo-randomly, so that held requests and back-to-back handshakes both occur.

// File: rtl/tgen_pkg.sv
package tgen_pkg;
  typedef enum logic [1:0] {
    MAP_COL_HI = 2'd0,
    MAP_COL_LO = 2'd1
  } addr_map_e;

  function automatic addr_map_e decode_map(input logic [1:0] sel);
    return (sel == 2'd0) ? MAP_COL_HI : MAP_COL_LO;
  endfunction
endpackage

// File: rtl/tgen_seq_ctr.sv
module tgen_seq_ctr #(
  parameter int NUM_RANKS = 2,
  parameter int BANK_W    = 3,
  parameter int RANK_W    = 1,
  parameter int PKT_W     = 8,
  parameter int SEQ_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [BANK_W:0]   banks_util_i,
  input  logic [PKT_W-1:0]  seq_pkts_i,
  input  logic [SEQ_W-1:0]  max_seq_i,
  output logic [PKT_W-1:0]  pkt_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [RANK_W-1:0] rank_o,
  output logic              phase_o
);
  logic [PKT_W-1:0]  pkt_q;
  logic [BANK_W-1:0] bank_q;
  logic [RANK_W-1:0] rank_q;
  logic [SEQ_W-1:0]  rseq_q;
  logic              phase_q;

  logic last_pkt, last_bank, last_rseq, last_rank;
  assign last_pkt  = (pkt_q == seq_pkts_i - 1'b1);
  assign last_bank = ({1'b0, bank_q} == banks_util_i - 1'b1);
  assign last_rseq = (rseq_q == max_seq_i - 1'b1);
  assign last_rank = (rank_q == RANK_W'(NUM_RANKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_q   <= '0;
      bank_q  <= '0;
      rank_q  <= '0;
      rseq_q  <= '0;
      phase_q <= 1'b0;
    end else if (adv_i) begin
      if (!last_pkt) begin
        pkt_q <= pkt_q + 1'b1;
      end else begin
        pkt_q <= '0;
        if (last_rseq && last_rank) begin
          // full rotation done: series count wraps
          bank_q  <= '0;
          rank_q  <= '0;
          rseq_q  <= '0;
          phase_q <= 1'b0;
        end else begin
          if (last_bank) begin
            bank_q  <= '0;
            phase_q <= ~phase_q;
          end else begin
            bank_q <= bank_q + 1'b1;
          end
          if (last_rseq) begin
            rseq_q <= '0;
            rank_q <= rank_q + 1'b1;
          end else begin
            rseq_q <= rseq_q + 1'b1;
          end
        end
      end
    end
  end

  assign pkt_o   = pkt_q;
  assign bank_o  = bank_q;
  assign rank_o  = rank_q;
  assign phase_o = phase_q;

  // R3
  bank_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (banks_util_i != 0) |-> ({1'b0, bank_o} < banks_util_i));

  // R4
  pkt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_pkts_i != 0) |-> (pkt_o < seq_pkts_i));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(pkt_o) && $stable(bank_o) && $stable(rank_o) && $stable(phase_o));
endmodule

// File: rtl/tgen_addr_pack.sv
module tgen_addr_pack
  import tgen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ROW_W  = 17,
  parameter int COL_W  = 4,
  parameter int RANK_W = 1,
  parameter int BANK_W = 3,
  parameter int CH_W   = 1,
  parameter int OFF_W  = 6
) (
  input  addr_map_e         map_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [RANK_W-1:0] rank_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [CH_W-1:0]  CH_ZERO  = '0;
  localparam logic [OFF_W-1:0] OFF_ZERO = '0;

  always_comb begin
    unique case (map_i)
      MAP_COL_HI: addr_o = {row_i, col_i, rank_i, bank_i, CH_ZERO, OFF_ZERO};
      default:    addr_o = {row_i, rank_i, bank_i, col_i, CH_ZERO, OFF_ZERO};
    endcase
  end
endmodule

// File: rtl/dram_rot_tgen.sv
module dram_rot_tgen
  import tgen_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64,
  parameter int PAGE_BYTES  = 1024,
  parameter int NUM_BANKS   = 8,
  parameter int NUM_RANKS   = 2,
  parameter int CH_W        = 1,
  parameter int PKT_W       = 8,
  parameter int SEQ_W       = 8,
  localparam int OFF_W  = $clog2(BLOCK_BYTES),
  localparam int COL_W  = $clog2(PAGE_BYTES / BLOCK_BYTES),
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int RANK_W = $clog2(NUM_RANKS),
  localparam int ROW_W  = ADDR_W - OFF_W - CH_W - COL_W - BANK_W - RANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        map_sel_i,
  input  logic [6:0]        read_pct_i,
  input  logic [BANK_W:0]   banks_util_i,
  input  logic [PKT_W-1:0]  seq_pkts_i,
  input  logic [SEQ_W-1:0]  max_seq_i,
  input  logic [ROW_W-1:0]  row_base_i,
  input  logic              req_ready_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              req_rd_o,
  output logic              cfg_err_o
);
  logic [PKT_W-1:0]  pkt;
  logic [BANK_W-1:0] bank;
  logic [RANK_W-1:0] rank;
  logic              phase;
  logic              hs;

  assign cfg_err_o   = !(read_pct_i == 7'd0 || read_pct_i == 7'd50 || read_pct_i == 7'd100);
  assign req_valid_o = !cfg_err_o;
  assign hs          = req_valid_o && req_ready_i;

  tgen_seq_ctr #(
    .NUM_RANKS(NUM_RANKS), .BANK_W(BANK_W), .RANK_W(RANK_W),
    .PKT_W(PKT_W), .SEQ_W(SEQ_W)
  ) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (hs),
    .banks_util_i(banks_util_i),
    .seq_pkts_i  (seq_pkts_i),
    .max_seq_i   (max_seq_i),
    .pkt_o       (pkt),
    .bank_o      (bank),
    .rank_o      (rank),
    .phase_o     (phase)
  );

  tgen_addr_pack #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W), .RANK_W(RANK_W),
    .BANK_W(BANK_W), .CH_W(CH_W), .OFF_W(OFF_W)
  ) u_pack (
    .map_i (decode_map(map_sel_i)),
    .row_i (row_base_i),
    .col_i (pkt[COL_W-1:0]),
    .rank_i(rank),
    .bank_i(bank),
    .addr_o(req_addr_o)
  );

  always_comb begin
    unique case (read_pct_i)
      7'd100:  req_rd_o = 1'b1;
      7'd50:   req_rd_o = ~phase;
      default: req_rd_o = 1'b0;
    endcase
  end

  // R7
  err_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !req_valid_o);

  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> $stable(req_addr_o) && $stable(req_rd_o));

  // R5
  all_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && read_pct_i == 7'd100) |-> req_rd_o);

  // R1
  low_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_addr_o[OFF_W+CH_W-1:0] == '0);
endmodule

// File: tb/dram_rot_tgen_tb.sv
module dram_rot_tgen_tb;
  localparam int ADDR_W = 32;
  localparam int ROW_W  = 17;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  map_sel_i = 2'd0;
  logic [6:0]  read_pct_i = 7'd50;
  logic [3:0]  banks_util_i = 4'd3;
  logic [7:0]  seq_pkts_i = 8'd2;
  logic [7:0]  max_seq_i = 8'd4;
  logic [ROW_W-1:0] row_base_i = '0;
  logic        req_ready_i = 1'b0;
  logic        req_valid_o;
  logic [ADDR_W-1:0] req_addr_o;
  logic        req_rd_o;
  logic        cfg_err_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int s_cnt, p_cnt;
  logic [ADDR_W-1:0] prev_addr;
  logic prev_held;

  always #10 clk = ~clk;

  dram_rot_tgen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .map_sel_i(map_sel_i), .read_pct_i(read_pct_i),
    .banks_util_i(banks_util_i), .seq_pkts_i(seq_pkts_i), .max_seq_i(max_seq_i),
    .row_base_i(row_base_i), .req_ready_i(req_ready_i), .req_valid_o(req_valid_o),
    .req_addr_o(req_addr_o), .req_rd_o(req_rd_o), .cfg_err_o(cfg_err_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Field layout, offset 6 bits and channel 1 bit at the bottom
  function automatic longint exp_addr(input int s, input int p);
    longint n, m, bank, rank, col, row;
    n = longint'(banks_util_i);
    m = longint'(max_seq_i);
    bank = s % n;           // R3
    rank = (s / m) % 2;     // R6
    col  = p % 16;          // R4
    row  = longint'(row_base_i);
    if (map_sel_i == 2'd0)  // R1
      return (row << 15) | (col << 11) | (rank << 10) | (bank << 7);
    return (row << 15) | (rank << 14) | (bank << 11) | (col << 7);  // R2
  endfunction

  function automatic logic exp_rd(input int s);
    if (read_pct_i == 7'd100) return 1'b1;
    if (read_pct_i == 7'd0) return 1'b0;
    return ((s / int'(banks_util_i)) % 2) == 0;  // R5
  endfunction

  task automatic do_reset;
    rst_ni = 1'b0;
    req_ready_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    s_cnt = 0;
    p_cnt = 0;
    prev_held = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(input int n_cyc, input int ready_pct);
    for (int i = 0; i < n_cyc; i++) begin
      string tag;
      tag = (map_sel_i == 2'd0) ? "R1" : "R2";
      chk("R7 valid", req_valid_o, 1);
      chk("R7 err", cfg_err_o, 0);
      chk(tag, req_addr_o, exp_addr(s_cnt, p_cnt));
      chk("R5 rd", req_rd_o, exp_rd(s_cnt));
      if (prev_held) chk("R8 hold", req_addr_o, prev_addr);
      prev_addr = req_addr_o;
      req_ready_i = (($urandom % 100) < ready_pct);
      prev_held = !req_ready_i;
      if (req_ready_i) begin
        p_cnt++;
        if (p_cnt == int'(seq_pkts_i)) begin
          p_cnt = 0;
          s_cnt++;
          if (s_cnt == int'(max_seq_i) * 2) s_cnt = 0;  // R6 wrap
        end
      end
      @(negedge clk);
    end
  endtask

  initial begin
    // A: mapping 0, alternating type, 3 banks, 2 pkts, 4 series per rank
    map_sel_i = 2'd0; read_pct_i = 7'd50; banks_util_i = 4'd3;
    seq_pkts_i = 8'd2; max_seq_i = 8'd4; row_base_i = 17'h1A5C3;
    do_reset();
    // R9: first request is series 0, column 0
    chk("R9 first", req_addr_o, longint'(17'h1A5C3) << 15);
    chk("R9 rd", req_rd_o, 1);
    run(300, 60);

    // B: mapping 1, all reads, 8 banks, 20 pkts (column wraps), 3 series per rank
    map_sel_i = 2'd1; read_pct_i = 7'd100; banks_util_i = 4'd8;
    seq_pkts_i = 8'd20; max_seq_i = 8'd3; row_base_i = 17'h00F0F;
    do_reset();
    run(600, 80);

    // C: select 3 behaves as mapping 1, all writes, 5 banks, 1 pkt
    map_sel_i = 2'd3; read_pct_i = 7'd0; banks_util_i = 4'd5;
    seq_pkts_i = 8'd1; max_seq_i = 8'd7; row_base_i = 17'h1FFFF;
    do_reset();
    run(200, 50);

    // D: 1 bank, alternating type every series, full-ready
    map_sel_i = 2'd0; read_pct_i = 7'd50; banks_util_i = 4'd1;
    seq_pkts_i = 8'd3; max_seq_i = 8'd2; row_base_i = 17'h00001;
    do_reset();
    run(100, 100);

    // E: unsupported read percentage suppresses requests
    read_pct_i = 7'd37;
    do_reset();
    req_ready_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      chk("R7 err set", cfg_err_o, 1);
      chk("R7 no valid", req_valid_o, 0);
      @(negedge clk);
    end
    // back to a legal value: state must not have moved (R8 advances only on handshake)
    req_ready_i = 1'b0;
    read_pct_i = 7'd100;
    @(negedge clk);
    chk("R8 no advance", req_addr_o, exp_addr(0, 0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule